// File: doc/BRIEF.md
# Dual-Tone Pair Frequency Classifier

This block sits behind the analog band-split filters and limiters of a telephone-signalling receiver. It takes two clean square waves, one from the low-frequency row band and one from the high-frequency column band, both sampled on the system clock. For each band it times the interval between consecutive rising edges in clock cycles and keeps the last few intervals. When every interval in that history, and also their mean, falls inside the acceptance window of one nominal tone, the band is reported as holding that tone.

When both bands hold a tone at once, the block raises an early-detect flag and presents the 4-bit keypad code of the row/column pair. The flag follows the signal condition directly, with no hold-off. Guard-time validation, debouncing and output latching are done by a downstream block that watches this flag. A band that stays silent for longer than its slowest legal period is declared empty. The period windows are derived from the clock frequency parameter, so the same logic serves any sampling clock fast enough to resolve the tolerance bands.

Top module: `dtmf_pair_classifier`

## Requirements
- R1: After reset, and until valid tones have been timed, `low_ok_o`, `high_ok_o` and `pair_valid_o` are 0 and `key_code_o` is 0000.
- R2: Each input passes through a two-flop synchronizer, and only its rising edges are timed. An edge first sampled high at clock edge n is reflected in the outputs after edge n+3. The duty cycle of an input has no effect on the result.
- R3: A measured period of P clock cycles matches tone i (frequency f) when floor(CLK_HZ*1000/(1025*f)) <= P <= floor(CLK_HZ*1000/(975*f)). Row tones are index 0..3 = 697, 770, 852, 941 Hz. Column tones are index 0..3 = 1209, 1336, 1477, 1633 Hz. These windows accept every tone within ±(1.5% + 2 Hz) of nominal and reject every tone that is off by 3.5% or more.
- R4: Each band counts cycles since its last rising edge, saturating at SAT = (upper window limit of tone index 0 of that band) + 1. Reaching SAT clears that band's valid flag and its history. The first rising edge after reset or after saturation only starts timing and produces no sample.
- R5: A band is valid only when its last AVG_N (default 4) periods each match the same tone and their mean (sum divided by AVG_N, rounded down) matches that tone as well. A single out-of-window period clears the flag until AVG_N good periods have been collected again.
- R6: `pair_valid_o` is high exactly when both band flags are high. It changes in the same cycle as `low_ok_o` and `high_ok_o`, so it falls as soon as either band is lost.
- R7: With row index r and column index c, the key code is as follows. Columns 0..2 with rows 0..2 give keys 1..9, coded 0001..1001. Row 3 gives * = 1011, 0 = 1010 and # = 1100. Column 3 gives A = 1101, B = 1110 and C = 1111 for rows 0..2, and D = 0000 for row 3.
- R8: `key_code_o` is 0000 whenever `pair_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| low_tone_i | input | 1 | Limited row-band square wave |
| high_tone_i | input | 1 | Limited column-band square wave |
| low_ok_o | output | 1 | Row band holds a valid tone |
| high_ok_o | output | 1 | Column band holds a valid tone |
| pair_valid_o | output | 1 | Early-detect: both bands valid |
| key_code_o | output | 4 | Keypad code of the current pair |

## Verification
All sixteen row/column pairs are played at nominal period, each followed by silence. This separates a wrong key mapping from a failure to rise or to clear. Tones at the edge of the acceptance band and just past the rejection limit, on both the fast and slow side of the lowest row tone and the highest column tone, show whether the windows sit on the correct side of each tolerance limit. Extreme duty cycles, a single outlier period inside a steady tone, and removal of one band while the other stays present show apart rising-edge-only timing, the per-period check on top of the mean, and the pair flag dropping with either band.

// File: rtl/dtmf_cls_pkg.sv
package dtmf_cls_pkg;

    localparam int unsigned TONES = 4;

    typedef struct packed {
        logic       low_ok;
        logic       high_ok;
        logic       pair;
        logic [3:0] key;
    } cls_out_t;

    // Nominal frequency of a tone; grp 0 = row band, 1 = column band
    function automatic int unsigned tone_hz(input logic grp, input int unsigned idx);
        int unsigned hz;
        if (grp == 1'b0) begin
            case (idx)
                0:       hz = 697;
                1:       hz = 770;
                2:       hz = 852;
                default: hz = 941;
            endcase
        end else begin
            case (idx)
                0:       hz = 1209;
                1:       hz = 1336;
                2:       hz = 1477;
                default: hz = 1633;
            endcase
        end
        return hz;
    endfunction

    // Shortest accepted period (frequency +2.5 %)
    function automatic int unsigned period_min(input int unsigned clk_hz, input logic grp,
                                               input int unsigned idx);
        longint unsigned num;
        longint unsigned den;
        num = 64'(clk_hz) * 64'd1000;
        den = 64'(tone_hz(grp, idx)) * 64'd1025;
        return 32'(num / den);
    endfunction

    // Longest accepted period (frequency -2.5 %)
    function automatic int unsigned period_max(input int unsigned clk_hz, input logic grp,
                                               input int unsigned idx);
        longint unsigned num;
        longint unsigned den;
        num = 64'(clk_hz) * 64'd1000;
        den = 64'(tone_hz(grp, idx)) * 64'd975;
        return 32'(num / den);
    endfunction

    // Row/column pair to keypad code
    function automatic logic [3:0] key_of(input logic [1:0] row, input logic [1:0] col);
        logic [3:0] k;
        if (col == 2'd3) begin
            k = (row == 2'd3) ? 4'd0 : 4'd13 + {2'b00, row};
        end else if (row == 2'd3) begin
            case (col)
                2'd0:    k = 4'd11;
                2'd1:    k = 4'd10;
                default: k = 4'd12;
            endcase
        end else begin
            k = {2'b00, row} * 4'd3 + {2'b00, col} + 4'd1;
        end
        return k;
    endfunction

endpackage

// File: rtl/dtmf_edge_sync.sv
module dtmf_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_i,
    output logic rise_o
);
    logic [STAGES:0] sh_d;
    logic [STAGES:0] sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], din_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

    // R2: an edge is reported for exactly one cycle
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/dtmf_period_meter.sv
module dtmf_period_meter
    import dtmf_cls_pkg::*;
#(
    parameter int unsigned CLK_HZ = 3579545,
    parameter bit          GROUP  = 1'b0,
    parameter int unsigned AVG_N  = 4      // power of two, at least 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rise_i,
    output logic       valid_o,
    output logic [1:0] idx_o
);
    localparam int unsigned SAT    = period_max(CLK_HZ, GROUP, 0) + 1;
    localparam int unsigned CNT_W  = $clog2(SAT + 2);
    localparam int unsigned LOG_N  = $clog2(AVG_N);
    localparam int unsigned SUM_W  = CNT_W + LOG_N;
    localparam int unsigned FILL_W = $clog2(AVG_N + 1);
    localparam logic [CNT_W-1:0]  SAT_C   = CNT_W'(SAT);
    localparam logic [FILL_W-1:0] FULL_C  = FILL_W'(AVG_N);
    localparam logic [FILL_W-1:0] LAST_C  = FILL_W'(AVG_N - 1);

    function automatic logic [TONES-1:0][CNT_W-1:0] lo_table();
        logic [TONES-1:0][CNT_W-1:0] tbl;
        for (int t = 0; t < TONES; t++) tbl[t] = CNT_W'(period_min(CLK_HZ, GROUP, t));
        return tbl;
    endfunction

    function automatic logic [TONES-1:0][CNT_W-1:0] hi_table();
        logic [TONES-1:0][CNT_W-1:0] tbl;
        for (int t = 0; t < TONES; t++) tbl[t] = CNT_W'(period_max(CLK_HZ, GROUP, t));
        return tbl;
    endfunction

    localparam logic [TONES-1:0][CNT_W-1:0] WIN_LO = lo_table();
    localparam logic [TONES-1:0][CNT_W-1:0] WIN_HI = hi_table();

    typedef struct packed {
        logic [CNT_W-1:0]            cnt;
        logic                        primed;
        logic [FILL_W-1:0]           fill;
        logic [AVG_N-1:0][CNT_W-1:0] hist;
        logic                        valid;
        logic [1:0]                  idx;
    } meter_t;

    meter_t st_d;
    meter_t st_q;

    // Datapath: candidate history including the period that ends now
    logic [CNT_W-1:0]                 sample_w;
    logic [AVG_N-1:0][CNT_W-1:0]      hist_new;
    logic [AVG_N:0][SUM_W-1:0]        acc;
    logic [TONES-1:0][AVG_N-1:0]      samp_hit;
    logic [TONES-1:0]                 mean_hit;
    logic [TONES-1:0]                 tone_hit;
    logic [1:0]                       hit_idx;

    assign sample_w    = st_q.cnt + 1'b1;
    assign hist_new[0] = sample_w;
    assign acc[0]      = '0;

    for (genvar k = 1; k < AVG_N; k++) begin : g_shift
        assign hist_new[k] = st_q.hist[k-1];
    end

    for (genvar k = 0; k < AVG_N; k++) begin : g_sum
        assign acc[k+1] = acc[k] + SUM_W'(hist_new[k]);
    end

    for (genvar t = 0; t < TONES; t++) begin : g_tone
        // floor(sum/N) in [lo,hi]  <=>  lo*N <= sum <= hi*N + N-1
        localparam logic [SUM_W-1:0] SUM_LO = SUM_W'(WIN_LO[t]) << LOG_N;
        localparam logic [SUM_W-1:0] SUM_HI = (SUM_W'(WIN_HI[t]) << LOG_N) + SUM_W'(AVG_N - 1);
        for (genvar k = 0; k < AVG_N; k++) begin : g_samp
            assign samp_hit[t][k] = (hist_new[k] >= WIN_LO[t]) && (hist_new[k] <= WIN_HI[t]);
        end
        assign mean_hit[t] = (acc[AVG_N] >= SUM_LO) && (acc[AVG_N] <= SUM_HI);
        assign tone_hit[t] = mean_hit[t] & (&samp_hit[t]);
    end

    always_comb begin
        if (tone_hit[3])      hit_idx = 2'd3;
        else if (tone_hit[2]) hit_idx = 2'd2;
        else if (tone_hit[1]) hit_idx = 2'd1;
        else                  hit_idx = 2'd0;
    end

    always_comb begin
        st_d = st_q;
        if (rise_i) begin
            if (st_q.primed) begin
                st_d.hist = hist_new;
                if (st_q.fill != FULL_C) st_d.fill = st_q.fill + 1'b1;
                if (st_q.fill >= LAST_C) begin
                    st_d.valid = |tone_hit;
                    if (|tone_hit) st_d.idx = hit_idx;
                end else begin
                    st_d.valid = 1'b0;
                end
            end
            st_d.primed = 1'b1;
            st_d.cnt    = '0;
        end else if (st_q.cnt == SAT_C) begin
            st_d.valid  = 1'b0;
            st_d.primed = 1'b0;
            st_d.fill   = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.valid;
    assign idx_o   = st_q.idx;

    // R4: a silent band loses its flag once the counter saturates
    a_r4_sat_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == SAT_C && !rise_i) |=> !valid_o);

    // R4: an edge that only starts timing never yields a valid band
    a_r4_unprimed_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && !st_q.primed) |=> !valid_o);

    // R5: validity needs a full history
    a_r5_full_history: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (st_q.fill == FULL_C));

endmodule

// File: rtl/dtmf_pair_classifier.sv
module dtmf_pair_classifier
    import dtmf_cls_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 3579545,
    parameter int unsigned AVG_N       = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       low_tone_i,
    input  logic       high_tone_i,
    output logic       low_ok_o,
    output logic       high_ok_o,
    output logic       pair_valid_o,
    output logic [3:0] key_code_o
);
    localparam int unsigned GROUPS = 2;

    logic [GROUPS-1:0]      tone_w;
    logic [GROUPS-1:0]      rise_w;
    logic [GROUPS-1:0]      band_ok;
    logic [GROUPS-1:0][1:0] band_idx;

    assign tone_w = {high_tone_i, low_tone_i};

    for (genvar g = 0; g < GROUPS; g++) begin : g_band
        dtmf_edge_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .din_i  (tone_w[g]),
            .rise_o (rise_w[g])
        );

        dtmf_period_meter #(
            .CLK_HZ (CLK_HZ),
            .GROUP  (1'(g)),
            .AVG_N  (AVG_N)
        ) u_meter (
            .clk     (clk),
            .rst_n   (rst_n),
            .rise_i  (rise_w[g]),
            .valid_o (band_ok[g]),
            .idx_o   (band_idx[g])
        );
    end

    cls_out_t out_d;
    cls_out_t out_q;

    always_comb begin
        out_d         = out_q;
        out_d.low_ok  = band_ok[0];
        out_d.high_ok = band_ok[1];
        out_d.pair    = band_ok[0] & band_ok[1];
        out_d.key     = (band_ok[0] & band_ok[1]) ? key_of(band_idx[0], band_idx[1]) : 4'd0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign low_ok_o     = out_q.low_ok;
    assign high_ok_o    = out_q.high_ok;
    assign pair_valid_o = out_q.pair;
    assign key_code_o   = out_q.key;

    // R6: the pair flag implies both band flags
    a_r6_pair_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid_o |-> (low_ok_o && high_ok_o));

    // R6: losing either band drops the pair flag on the next edge
    a_r6_pair_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (!band_ok[0] || !band_ok[1]) |=> !pair_valid_o);

    // R8: no code is shown without a pair
    a_r8_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_valid_o |-> (key_code_o == 4'b0000));

endmodule

// File: tb/dtmf_pair_classifier_test.sv
module dtmf_pair_classifier_test;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int CLK_HZ = 358000;
    localparam int AVG    = 4;
    localparam int HOLD   = 3200;
    localparam int QUIET  = 700;
    localparam int LIMIT  = 180000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       low_tone = 1'b0;
    logic       high_tone = 1'b0;
    logic       low_ok, high_ok, pair_valid;
    logic [3:0] key_code;

    dtmf_pair_classifier #(.CLK_HZ(CLK_HZ), .AVG_N(AVG)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .low_tone_i   (low_tone),
        .high_tone_i  (high_tone),
        .low_ok_o     (low_ok),
        .high_ok_o    (high_ok),
        .pair_valid_o (pair_valid),
        .key_code_o   (key_code)
    );

    always #2.5 clk = ~clk;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit done = 0;

    int LOW_HZ[4]  = '{697, 770, 852, 941};
    int HIGH_HZ[4] = '{1209, 1336, 1477, 1633};

    function automatic int hz(int g, int t);
        return (g == 0) ? LOW_HZ[t] : HIGH_HZ[t];
    endfunction
    function automatic int win_lo(int g, int t);
        return int'((longint'(CLK_HZ) * 1000) / (longint'(hz(g, t)) * 1025));
    endfunction
    function automatic int win_hi(int g, int t);
        return int'((longint'(CLK_HZ) * 1000) / (longint'(hz(g, t)) * 975));
    endfunction
    function automatic int classify(int g, int p);
        for (int t = 0; t < 4; t++) if (p >= win_lo(g, t) && p <= win_hi(g, t)) return t;
        return -1;
    endfunction
    function automatic int nominal(int g, int t);
        return (CLK_HZ + hz(g, t) / 2) / hz(g, t);
    endfunction
    function automatic int code_of(byte ch);
        if (ch >= "1" && ch <= "9") return int'(ch - "0");
        case (ch)
            "0": return 10;
            "*": return 11;
            "#": return 12;
            "A": return 13;
            "B": return 14;
            "C": return 15;
            default: return 0;
        endcase
    endfunction

    string KEYS = "123A456B789C*0#D";

    // ---------------- stimulus generators ----------------
    int per[2]  = '{0, 0};
    int duty[2] = '{50, 50};
    int gc[2]   = '{0, 0};

    always @(negedge clk) begin
        for (int g = 0; g < 2; g++) begin
            logic v;
            if (per[g] == 0) begin
                v = 1'b0; gc[g] = 0;
            end else begin
                v = (gc[g] < (per[g] * duty[g]) / 100);
                gc[g] = (gc[g] + 1 >= per[g]) ? 0 : gc[g] + 1;
            end
            if (g == 0) low_tone = v; else high_tone = v;
        end
    end

    // ---------------- reference model ----------------
    bit m_h1[2], m_h2[2], m_h3[2], m_primed[2], m_valid[2];
    int m_cnt[2], m_idx[2];
    int hq0[$];
    int hq1[$];
    bit e_low, e_high, e_pair;
    int e_key;

    task automatic m_step(input int g, input bit pin, ref int q[$]);
        bit rise;
        int sat;
        rise = m_h2[g] && !m_h3[g];
        m_h3[g] = m_h2[g]; m_h2[g] = m_h1[g]; m_h1[g] = pin;
        sat = win_hi(g, 0) + 1;
        if (rise) begin
            if (m_primed[g]) begin
                q.push_back(m_cnt[g] + 1);
                if (q.size() > AVG) void'(q.pop_front());
                if (q.size() == AVG) begin
                    int c0, sum;
                    bit ok;
                    c0 = classify(g, q[0]); ok = (c0 >= 0); sum = 0;
                    for (int i = 0; i < AVG; i++) begin
                        if (classify(g, q[i]) != c0) ok = 0;
                        sum += q[i];
                    end
                    if (classify(g, sum / AVG) != c0) ok = 0;
                    m_valid[g] = ok;
                    if (ok) m_idx[g] = c0;
                end else m_valid[g] = 0;
            end
            m_primed[g] = 1; m_cnt[g] = 0;
        end else if (m_cnt[g] == sat) begin
            m_valid[g] = 0; m_primed[g] = 0; q.delete();
        end else begin
            m_cnt[g]++;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            for (int g = 0; g < 2; g++) begin
                m_h1[g] = 0; m_h2[g] = 0; m_h3[g] = 0; m_primed[g] = 0;
                m_valid[g] = 0; m_cnt[g] = 0; m_idx[g] = 0;
            end
            hq0.delete(); hq1.delete();
            e_low = 0; e_high = 0; e_pair = 0; e_key = 0;
        end else begin
            e_low  = m_valid[0];
            e_high = m_valid[1];
            e_pair = m_valid[0] && m_valid[1];
            e_key  = e_pair ? code_of(KEYS[m_idx[0] * 4 + m_idx[1]]) : 0;
            m_step(0, low_tone, hq0);
            m_step(1, high_tone, hq1);
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s at cycle %0d: got %0d expected %0d", tag, cycles, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (cycles > 1 && !done) begin
            check("R3 low_ok", int'(low_ok), int'(e_low));
            check("R3 high_ok", int'(high_ok), int'(e_high));
            check("R6 pair_valid", int'(pair_valid), int'(e_pair));
            check("R7 key_code", int'(key_code), e_key);
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask
    task automatic play(input int pl, input int ph);
        @(posedge clk); #1;
        per[0] = pl; per[1] = ph;
    endtask
    function automatic int off_period(int g, int t, real scale, real add);
        return int'(real'(CLK_HZ) / (real'(hz(g, t)) * scale + add));
    endfunction

    task automatic edge_case(input int g, input int t, input real scale, input real add,
                             input int expect_ok, input string tag);
        int p;
        p = off_period(g, t, scale, add);
        if (g == 0) play(p, nominal(1, 0)); else play(nominal(0, 3), p);
        wait_cyc(HOLD);
        check(tag, (g == 0) ? int'(low_ok) : int'(high_ok), expect_ok);
        play(0, 0);
        wait_cyc(QUIET);
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > LIMIT && !done) begin
            miscompares++;
            $display("FAIL watchdog: got %0d cycles expected below %0d", cycles, LIMIT);
            finish_run();
        end
    end

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(3);
        // R1: quiet outputs after reset
        check("R1 low_ok", int'(low_ok), 0);
        check("R1 high_ok", int'(high_ok), 0);
        check("R1 pair_valid", int'(pair_valid), 0);
        check("R1 key_code", int'(key_code), 0);

        // R7: every key at nominal frequency, then silence (R4, R8)
        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < 4; c++) begin
                play(nominal(0, r), nominal(1, c));
                wait_cyc(HOLD);
                check("R6 pair present", int'(pair_valid), 1);
                check("R7 key map", int'(key_code), code_of(KEYS[r * 4 + c]));
                play(0, 0);
                wait_cyc(QUIET);
                check("R4 silence clears pair", int'(pair_valid), 0);
                check("R8 code idle", int'(key_code), 0);
            end
        end

        // R3: tolerance band edges on the extreme tones
        edge_case(0, 0, 1.015, 2.0, 1, "R3 row fast accept");
        edge_case(0, 0, 0.985, -2.0, 1, "R3 row slow accept");
        edge_case(0, 0, 1.035, 0.0, 0, "R3 row fast reject");
        edge_case(0, 0, 0.965, 0.0, 0, "R3 row slow reject");
        edge_case(1, 3, 1.015, 2.0, 1, "R3 col fast accept");
        edge_case(1, 3, 0.985, -2.0, 1, "R3 col slow accept");
        edge_case(1, 3, 1.035, 0.0, 0, "R3 col fast reject");
        edge_case(1, 3, 0.965, 0.0, 0, "R3 col slow reject");

        // R2: extreme duty cycles do not matter
        duty[0] = 10; duty[1] = 90;
        play(nominal(0, 2), nominal(1, 2));
        wait_cyc(HOLD);
        check("R2 duty-insensitive key 9", int'(key_code), 9);
        play(0, 0);
        wait_cyc(QUIET);
        duty[0] = 50; duty[1] = 50;

        // R5: one outlier period inside a steady row tone
        play(nominal(0, 0), nominal(1, 1));
        wait_cyc(HOLD);
        check("R5 steady before outlier", int'(low_ok), 1);
        do wait_cyc(1); while (gc[0] != 0);
        per[0] = 460;
        wait_cyc(460);
        per[0] = nominal(0, 0);
        wait_cyc(30);
        check("R5 outlier clears row", int'(low_ok), 0);
        check("R6 pair follows row loss", int'(pair_valid), 0);
        wait_cyc(AVG * 520 + 60);
        check("R5 row recovers", int'(low_ok), 1);
        check("R7 key 2 after recovery", int'(key_code), 2);

        // R6/R4: row removed, column stays
        play(0, nominal(1, 1));
        wait_cyc(QUIET);
        check("R4 row saturated", int'(low_ok), 0);
        check("R6 column alone", int'(high_ok), 1);
        check("R6 no pair", int'(pair_valid), 0);
        check("R8 code idle single band", int'(key_code), 0);
        play(0, 0);
        wait_cyc(QUIET);

        finish_run();
    end

endmodule